// File: doc/BRIEF.md
# Code and Data Address Generator

This block keeps the program counter and the data pointer of a small 8-bit controller core. It also produces the address that the core presents to code memory. The core's decoder chooses one operation for each enabled step and supplies the accumulator, the immediate bytes, a 3-bit page field and the length of the current instruction.

The block computes the address of the next instruction (`pc + len`) once. It uses that value for plain advance, for table lookups relative to the program counter, and for jumps within a 2 KiB block. The data pointer is kept as two separate bytes. It can be loaded from the two immediate bytes or incremented as a single 16-bit quantity. Table lookups add the unsigned accumulator to a 16-bit base with a full carry chain. The lookup result is driven onto the fetch address during the same cycle as the request. In every other cycle the fetch address is the program counter.

Top module: `cdag_top`

## Requirements
- R1: While `rst_ni` is low, the program counter and the data pointer are 0000h, and the fetch address equals the program counter.
- R2: When `step_i` is low, the program counter and the data pointer keep their values, and the fetch address equals the program counter.
- R3: Operation code 1 (load pointer) writes `imm_hi_i` to the pointer high byte and `imm_lo_i` to the pointer low byte. Loading 4567h gives a high byte of 45h and a low byte of 67h.
- R4: Operation code 2 (pointer increment) adds 1 to the pointer modulo 65536. A wrap of the low byte from FFh to 00h increments the high byte.
- R5: Operation code 3 (lookup from pointer) drives the fetch address to the zero-extended accumulator plus the data pointer, using a full 16-bit add. The data pointer is left unchanged.
- R6: Operation code 4 (lookup from counter) drives the fetch address to the accumulator plus `pc + len_i`, modulo 65536. The program counter becomes `pc + len_i`.
- R7: Operation code 5 (block jump) sets the program counter to {bits 15:11 of `pc + len_i`, `page_i`, `imm_lo_i`}.
- R8: Operation code 6 (long jump) sets the program counter to {`imm_hi_i`, `imm_lo_i`}.
- R9: Operation codes 0, 1, 2, 3 and 7 advance the program counter by `len_i` modulo 65536. No operation other than codes 1 and 2 alters the data pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Execute the selected operation in this cycle |
| op_i | input | 3 | Operation code (0 advance, 1 load pointer, 2 increment pointer, 3 lookup from pointer, 4 lookup from counter, 5 block jump, 6 long jump, 7 advance) |
| acc_i | input | 8 | Accumulator value, treated as unsigned |
| imm_hi_i | input | 8 | First immediate byte |
| imm_lo_i | input | 8 | Second immediate byte |
| page_i | input | 3 | Page field of a block jump |
| len_i | input | 2 | Length in bytes of the current instruction |
| pc_o | output | 16 | Program counter |
| dptr_hi_o | output | 8 | Data pointer high byte |
| dptr_lo_o | output | 8 | Data pointer low byte |
| fetch_addr_o | output | 16 | Code memory address |

## Verification
The hardest cases to reach from the ports are the ones where the next-instruction address itself crosses a boundary. The first is a block jump taken from the last bytes of a 2 KiB block, where the upper five bits must come from the next block. The second is a counter-relative lookup whose base and sum wrap past FFFFh. Random stimulus rarely produces these, so long jumps are used to place the counter at 07FEh and FFFEh before the boundary case is issued. Pointer loads set up 00FFh, FFFFh and 01F0h to exercise the byte carry on increment and on lookup. A seeded random mix of all eight codes follows the directed cases.

// File: rtl/cdag_pkg.sv
package cdag_pkg;
  localparam int ADDR_W = 16;
  localparam int BYTE_W = 8;
  localparam int PAGE_W = 3;
  localparam int LEN_W  = 2;

  typedef enum logic [2:0] {
    OP_ADV   = 3'd0,
    OP_LDDP  = 3'd1,
    OP_INCDP = 3'd2,
    OP_LUDP  = 3'd3,
    OP_LUPC  = 3'd4,
    OP_BJMP  = 3'd5,
    OP_LJMP  = 3'd6,
    OP_RSV   = 3'd7
  } op_e;
endpackage

// File: rtl/cdag_dptr.sv
module cdag_dptr #(
  parameter int BYTE_W = 8,
  localparam int WIDE_W = 2 * BYTE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              inc_i,
  input  logic [BYTE_W-1:0] imm_hi_i,
  input  logic [BYTE_W-1:0] imm_lo_i,
  output logic [BYTE_W-1:0] hi_o,
  output logic [BYTE_W-1:0] lo_o
);
  logic [BYTE_W-1:0] hi_q, lo_q;
  logic              lo_wrap;

  assign lo_wrap = &lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_q <= '0;
      lo_q <= '0;
    end else if (load_i) begin
      hi_q <= imm_hi_i;
      lo_q <= imm_lo_i;
    end else if (inc_i) begin
      lo_q <= lo_q + 1'b1;
      if (lo_wrap) hi_q <= hi_q + 1'b1;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;

  // R4
  inc_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i) |=> ({hi_o, lo_o} == WIDE_W'($past({hi_o, lo_o}) + 1'b1)));

  // R9
  dptr_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable({hi_o, lo_o}));
endmodule

// File: rtl/cdag_pc.sv
module cdag_pc
  import cdag_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int BW = BYTE_W,
  parameter int PW = PAGE_W,
  parameter int LW = LEN_W,
  localparam int BLK_LSB = BW + PW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  op_e           op_i,
  input  logic [LW-1:0] len_i,
  input  logic [PW-1:0] page_i,
  input  logic [BW-1:0] imm_hi_i,
  input  logic [BW-1:0] imm_lo_i,
  output logic [AW-1:0] pc_o,
  output logic [AW-1:0] pc_adv_o
);
  logic [AW-1:0] pc_q, pc_d, pc_adv;

  assign pc_adv = pc_q + AW'(len_i);

  always_comb begin
    unique case (op_i)
      OP_BJMP: pc_d = {pc_adv[AW-1:BLK_LSB], page_i, imm_lo_i};
      OP_LJMP: pc_d = AW'({imm_hi_i, imm_lo_i});
      default: pc_d = pc_adv;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pc_q <= '0;
    else if (step_i) pc_q <= pc_d;
  end

  assign pc_o     = pc_q;
  assign pc_adv_o = pc_adv;

  // R8
  ljmp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && op_i == OP_LJMP) |=> (pc_o == AW'($past({imm_hi_i, imm_lo_i}))));

  // R7
  bjmp_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && op_i == OP_BJMP) |=> (pc_o[BLK_LSB-1:0] == $past({page_i, imm_lo_i})));

  // R2
  pc_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(pc_o));
endmodule

// File: rtl/cdag_lookup.sv
module cdag_lookup #(
  parameter int AW = 16,
  parameter int BW = 8
) (
  input  logic [BW-1:0] acc_i,
  input  logic [AW-1:0] base_i,
  output logic [AW-1:0] addr_o
);
  // full-width add so the low-byte carry ripples upward
  assign addr_o = base_i + AW'(acc_i);
endmodule

// File: rtl/cdag_top.sv
module cdag_top
  import cdag_pkg::*;
(
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                step_i,
  input  logic [2:0]          op_i,
  input  logic [BYTE_W-1:0]   acc_i,
  input  logic [BYTE_W-1:0]   imm_hi_i,
  input  logic [BYTE_W-1:0]   imm_lo_i,
  input  logic [PAGE_W-1:0]   page_i,
  input  logic [LEN_W-1:0]    len_i,
  output logic [ADDR_W-1:0]   pc_o,
  output logic [BYTE_W-1:0]   dptr_hi_o,
  output logic [BYTE_W-1:0]   dptr_lo_o,
  output logic [ADDR_W-1:0]   fetch_addr_o
);
  op_e           op;
  logic [ADDR_W-1:0] pc_adv, dptr, lu_base, lu_addr;
  logic          is_lookup;

  assign op        = op_e'(op_i);
  assign dptr      = {dptr_hi_o, dptr_lo_o};
  assign is_lookup = step_i && (op == OP_LUDP || op == OP_LUPC);
  assign lu_base   = (op == OP_LUPC) ? pc_adv : dptr;

  cdag_pc u_pc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step_i),
    .op_i    (op),
    .len_i   (len_i),
    .page_i  (page_i),
    .imm_hi_i(imm_hi_i),
    .imm_lo_i(imm_lo_i),
    .pc_o    (pc_o),
    .pc_adv_o(pc_adv)
  );

  cdag_dptr #(.BYTE_W(BYTE_W)) u_dptr (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (step_i && op == OP_LDDP),
    .inc_i   (step_i && op == OP_INCDP),
    .imm_hi_i(imm_hi_i),
    .imm_lo_i(imm_lo_i),
    .hi_o    (dptr_hi_o),
    .lo_o    (dptr_lo_o)
  );

  cdag_lookup #(.AW(ADDR_W), .BW(BYTE_W)) u_lookup (
    .acc_i (acc_i),
    .base_i(lu_base),
    .addr_o(lu_addr)
  );

  assign fetch_addr_o = is_lookup ? lu_addr : pc_o;

  // R5
  lu_dp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && op == OP_LUDP) |-> (fetch_addr_o - {dptr_hi_o, dptr_lo_o} == ADDR_W'(acc_i)));

  // R6
  lu_pc_adv_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && op == OP_LUPC) |=> (pc_o == ADDR_W'($past(fetch_addr_o) - $past(acc_i))));

  // R3
  ld_dp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && op == OP_LDDP) |=> (dptr_hi_o == $past(imm_hi_i) && dptr_lo_o == $past(imm_lo_i)));
endmodule

// File: tb/cdag_top_tb_top.sv
module cdag_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0;
  logic [2:0]  op = '0;
  logic [7:0]  acc = '0, ihi = '0, ilo = '0;
  logic [2:0]  page = '0;
  logic [1:0]  len = '0;
  logic [15:0] pc, fetch;
  logic [7:0]  dhi, dlo;
  int          n_chk = 0, n_bad = 0;
  logic [15:0] m_pc = '0, m_dp = '0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  cdag_top dut_i (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .op_i(op), .acc_i(acc),
    .imm_hi_i(ihi), .imm_lo_i(ilo), .page_i(page), .len_i(len),
    .pc_o(pc), .dptr_hi_o(dhi), .dptr_lo_o(dlo), .fetch_addr_o(fetch)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_fetch(logic s, logic [2:0] o, logic [7:0] a, logic [1:0] l);
    if (s && o == 3'd3) return m_dp + 16'(a);
    if (s && o == 3'd4) return m_pc + 16'(l) + 16'(a);
    return m_pc;
  endfunction

  function automatic logic [15:0] next_pc(logic s, logic [2:0] o, logic [1:0] l,
                                          logic [2:0] pg, logic [7:0] h, logic [7:0] lo);
    logic [15:0] adv;
    adv = m_pc + 16'(l);
    if (!s) return m_pc;
    if (o == 3'd5) return {adv[15:11], pg, lo};
    if (o == 3'd6) return {h, lo};
    return adv;
  endfunction

  function automatic logic [15:0] next_dp(logic s, logic [2:0] o, logic [7:0] h, logic [7:0] lo);
    if (s && o == 3'd1) return {h, lo};
    if (s && o == 3'd2) return m_dp + 16'd1;
    return m_dp;
  endfunction

  function automatic string tag_of(logic [2:0] o);
    case (o)
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R9";
    endcase
  endfunction

  task automatic run_op(logic s, logic [2:0] o, logic [7:0] a, logic [7:0] h,
                        logic [7:0] lo, logic [2:0] pg, logic [1:0] l);
    logic [15:0] e_pc, e_dp;
    string t;
    @(negedge clk);
    step = s; op = o; acc = a; ihi = h; ilo = lo; page = pg; len = l;
    t = s ? tag_of(o) : "R2";
    #1;
    check({t, " fetch"}, fetch, exp_fetch(s, o, a, l));
    e_pc = next_pc(s, o, l, pg, h, lo);
    e_dp = next_dp(s, o, h, lo);
    @(posedge clk);
    #1;
    m_pc = e_pc; m_dp = e_dp;
    check({t, " pc"}, pc, m_pc);
    check({t, " dptr"}, {dhi, dlo}, m_dp);
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    int unused;
    unused = $urandom(32'd1957);
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1 pc", pc, 16'h0000);
    check("R1 dptr", {dhi, dlo}, 16'h0000);
    check("R1 fetch", fetch, pc);
    rst_n = 1'b1;
    // R3 load
    run_op(1, 3'd1, 8'h00, 8'h45, 8'h67, 3'd0, 2'd3);
    check("R3 hi byte", 16'(dhi), 16'h0045);
    // R4 carry and wrap
    run_op(1, 3'd1, 8'h00, 8'h00, 8'hFF, 3'd0, 2'd3);
    run_op(1, 3'd2, 8'h00, 8'h00, 8'h00, 3'd0, 2'd1);
    check("R4 carry", {dhi, dlo}, 16'h0100);
    run_op(1, 3'd1, 8'h00, 8'hFF, 8'hFF, 3'd0, 2'd3);
    run_op(1, 3'd2, 8'h00, 8'h00, 8'h00, 3'd0, 2'd1);
    check("R4 wrap", {dhi, dlo}, 16'h0000);
    // R5 lookup carry into high byte
    run_op(1, 3'd1, 8'h00, 8'h01, 8'hF0, 3'd0, 2'd3);
    run_op(1, 3'd3, 8'h20, 8'h00, 8'h00, 3'd0, 2'd1);
    // R2 idle with noisy inputs
    run_op(0, 3'd6, 8'hAA, 8'h12, 8'h34, 3'd5, 2'd2);
    // R7 block jump from end of block
    run_op(1, 3'd6, 8'h00, 8'h07, 8'hFE, 3'd0, 2'd3);
    run_op(1, 3'd5, 8'h00, 8'h00, 8'h3C, 3'd2, 2'd2);
    check("R7 next block", pc, 16'h0A3C);
    // R6 counter lookup wrapping
    run_op(1, 3'd6, 8'h00, 8'hFF, 8'hFE, 3'd0, 2'd3);
    run_op(1, 3'd4, 8'h05, 8'h00, 8'h00, 3'd0, 2'd1);
    check("R6 pc advanced", pc, 16'hFFFF);
    // R9 reserved code wraps pc
    run_op(1, 3'd7, 8'h00, 8'h00, 8'h00, 3'd0, 2'd3);
    for (int i = 0; i < 3000; i++) begin
      run_op(($urandom % 5) != 0, 3'($urandom), 8'($urandom), 8'($urandom),
             8'($urandom), 3'($urandom), 2'($urandom));
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule